// File: doc/BRIEF.md
# Mixed-Width Atomic Compare-Swap Unit

This block sits on the memory side, in front of a small on-chip store organised as 128-bit lines. Several requesters send compare-and-swap operations to it. Each operation carries a byte address, an operand width of 64 or 128 bits, an expected value and a desired value. Operations of both widths may target the same line, and even the same starting byte. The unit runs them strictly one after another.

A round-robin arbiter picks one pending requester at a time. The unit then reads the addressed line and holds a lock on it until the matching write. It compares the addressed operand against the expected value. It always writes the line back: the merged desired value when the comparison matches, and the unchanged old contents when it does not. One cycle after the write, the granted requester receives a success bit together with the value the operation observed.

A request whose address does not suit its width gets an error response. Such a request never touches the store.

Top module: `cas_unit`

## Requirements
- R1: After reset, no grant, response or lock is active, and every line of the store reads as zero.
- R2: A 128-bit operation whose expected value equals the whole line stores the desired value, reports success and returns the old line.
- R3: A 64-bit operation acts on the line half chosen by address bit 3 (0 = bits 63:0, 1 = bits 127:64). On success only that half takes desired bits 63:0, and the other half keeps its value.
- R4: On a mismatch the line is left as it was, success reads 0, and the observed old value is still returned.
- R5: For a 64-bit operation the returned value holds the observed half in bits 63:0 and zeros in bits 127:64.
- R6: Racing operations of different widths on one line are serialized. The later one sees the whole effect of the earlier one, so a 128-bit compare fails after a 64-bit swap has changed either half of the line.
- R7: A 128-bit request with any of address bits 3:0 set, or a 64-bit request with any of address bits 2:0 set, gets an error response with success 0 and data 0. It takes no lock and leaves the store unchanged.
- R8: At most one grant is given per cycle, and only to a requester that is asking. The search starts at the requester after the last one granted, and at requester 0 after reset.
- R9: A response goes only to the granted requester. It arrives 3 cycles after the grant cycle for an accepted operation and 2 cycles after it for a rejected one. No new grant is given before that response.
- R10: The line lock is raised by the read and lasts exactly one cycle, up to the write. The response follows in the next cycle, and no grant is given while the lock is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Request pending, one bit per requester; held until granted |
| reqWide | input | NUM_REQ | Operand width per requester: 1 = 128-bit, 0 = 64-bit |
| reqAddr | input | NUM_REQ x ADDR_W | Byte address per requester |
| reqExpect | input | NUM_REQ x LINE_W | Expected value per requester (bits 63:0 for 64-bit operations) |
| reqDesire | input | NUM_REQ x LINE_W | Desired value per requester (bits 63:0 for 64-bit operations) |
| reqGrant | output | NUM_REQ | One-hot acceptance strobe |
| rspValid | output | NUM_REQ | One-hot response strobe to the granted requester |
| rspOk | output | 1 | Comparison matched and the swap took place |
| rspErr | output | 1 | Request rejected for misalignment |
| rspData | output | LINE_W | Observed old value, zero-extended for 64-bit operations |
| lockActive | output | 1 | Line lock held between read and write |
| lockLine | output | ADDR_W-4 | Index of the locked line |

## Verification
Every line of the store receives a full-line swap, then matched and mismatched swaps on each half in turn. Each step is followed by a deliberately failing full-width compare that reads the line back, so a write to the wrong half, a lost neighbouring half, or a skipped write-back each shows up as a wrong observed value. Simultaneous requests of both widths to the same line are issued with each requester taking the lock first in turn. The bench models both orders and shows that the later compare sees the earlier swap. Misaligned addresses of each width check the rejection path, its shorter latency and the absence of any lock, and a later read-back confirms that the store was left untouched.

// File: rtl/cas_pkg.sv
package cas_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACQ,
    ST_WRITE,
    ST_RESP
  } casState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic readLine;
    logic writeLine;
    logic reject;
  } casStrobe_t;

endpackage

// File: rtl/cas_arb.sv
module cas_arb #(
  parameter int NUM_REQ = 2,
  localparam int ID_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [NUM_REQ-1:0] reqValid,
  output logic [NUM_REQ-1:0] grant,
  output logic [ID_W-1:0]    winId
);

  logic [ID_W-1:0] ptr;
  logic            found;

  always_comb begin
    grant = '0;
    winId = '0;
    found = 1'b0;
    for (int k = 0; k < NUM_REQ; k++) begin
      int idx;
      idx = (int'(ptr) + k) % NUM_REQ;
      if (enable && !found && reqValid[idx]) begin
        found      = 1'b1;
        grant[idx] = 1'b1;
        winId      = ID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (found) begin
      ptr <= (winId == ID_W'(NUM_REQ - 1)) ? '0 : winId + 1'b1;
    end
  end

endmodule

// File: rtl/cas_ctrl.sv
module cas_ctrl
  import cas_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyGrant,
  input  logic       misaligned,
  output casStrobe_t strobe,
  output logic       idle,
  output logic       respond
);

  casState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (anyGrant) begin
        strobe.capture = 1'b1;
        nextState      = ST_ACQ;
      end
      ST_ACQ: if (misaligned) begin
        strobe.reject = 1'b1;
        nextState     = ST_RESP;
      end else begin
        strobe.readLine = 1'b1;
        nextState       = ST_WRITE;
      end
      ST_WRITE: begin
        strobe.writeLine = 1'b1;
        nextState        = ST_RESP;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign idle    = (state == ST_IDLE);
  assign respond = (state == ST_RESP);

endmodule

// File: rtl/cas_dp.sv
module cas_dp
  import cas_pkg::*;
#(
  parameter int NUM_REQ = 2,
  parameter int ADDR_W  = 8,
  parameter int LINE_W  = 128,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int HALF_W = LINE_W / 2,
  localparam int OFS_W  = $clog2(LINE_W / 8),
  localparam int HSEL   = OFS_W - 1,
  localparam int IDX_W  = ADDR_W - OFS_W,
  localparam int LINES  = 1 << IDX_W
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  casStrobe_t                      strobe,
  input  logic [ID_W-1:0]                 winId,
  input  logic [NUM_REQ-1:0]              reqWide,
  input  logic [NUM_REQ-1:0][ADDR_W-1:0]  reqAddr,
  input  logic [NUM_REQ-1:0][LINE_W-1:0]  reqExpect,
  input  logic [NUM_REQ-1:0][LINE_W-1:0]  reqDesire,
  output logic                            misaligned,
  output logic                            lockHeld,
  output logic [IDX_W-1:0]                lockLine,
  output logic [ID_W-1:0]                 owner,
  output logic                            okR,
  output logic                            errR,
  output logic [LINE_W-1:0]               dataR
);

  logic              curWide;
  logic [ADDR_W-1:0] curAddr;
  logic [LINE_W-1:0] curExp, curDes, oldLine;
  logic [LINE_W-1:0] mem [LINES];

  logic [IDX_W-1:0]  lineIdx;
  logic              hiHalf, match;
  logic [HALF_W-1:0] oldHalf;
  logic [LINE_W-1:0] observed, swapped, newLine;

  assign lineIdx    = curAddr[ADDR_W-1:OFS_W];
  assign hiHalf     = curAddr[HSEL];
  assign misaligned = curWide ? (curAddr[OFS_W-1:0] != '0)
                              : (curAddr[HSEL-1:0] != '0);

  always_comb begin
    oldHalf  = hiHalf ? oldLine[LINE_W-1:HALF_W] : oldLine[HALF_W-1:0];
    observed = curWide ? oldLine : {{HALF_W{1'b0}}, oldHalf};
    match    = curWide ? (oldLine == curExp) : (oldHalf == curExp[HALF_W-1:0]);
    if (curWide)     swapped = curDes;
    else if (hiHalf) swapped = {curDes[HALF_W-1:0], oldLine[HALF_W-1:0]};
    else             swapped = {oldLine[LINE_W-1:HALF_W], curDes[HALF_W-1:0]};
    newLine = match ? swapped : oldLine;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWide  <= 1'b0;
      curAddr  <= '0;
      curExp   <= '0;
      curDes   <= '0;
      owner    <= '0;
      oldLine  <= '0;
      lockHeld <= 1'b0;
      lockLine <= '0;
      okR      <= 1'b0;
      errR     <= 1'b0;
      dataR    <= '0;
    end else begin
      if (strobe.capture) begin
        curWide <= reqWide[winId];
        curAddr <= reqAddr[winId];
        curExp  <= reqExpect[winId];
        curDes  <= reqDesire[winId];
        owner   <= winId;
      end
      if (strobe.readLine) begin
        oldLine  <= mem[lineIdx];
        lockHeld <= 1'b1;
        lockLine <= lineIdx;
      end
      if (strobe.writeLine) begin
        lockHeld <= 1'b0;
        okR      <= match;
        errR     <= 1'b0;
        dataR    <= observed;
      end
      if (strobe.reject) begin
        okR   <= 1'b0;
        errR  <= 1'b1;
        dataR <= '0;
      end
    end
  end

  // Locked write cycle: always performed, old data on mismatch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) mem[i] <= '0;
    end else if (strobe.writeLine) begin
      mem[lineIdx] <= newLine;
    end
  end

endmodule

// File: rtl/cas_unit.sv
module cas_unit
  import cas_pkg::*;
#(
  parameter int NUM_REQ = 2,
  parameter int ADDR_W  = 8,
  parameter int LINE_W  = 128,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int IDX_W  = ADDR_W - $clog2(LINE_W / 8)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_REQ-1:0]             reqValid,
  input  logic [NUM_REQ-1:0]             reqWide,
  input  logic [NUM_REQ-1:0][ADDR_W-1:0] reqAddr,
  input  logic [NUM_REQ-1:0][LINE_W-1:0] reqExpect,
  input  logic [NUM_REQ-1:0][LINE_W-1:0] reqDesire,
  output logic [NUM_REQ-1:0]             reqGrant,
  output logic [NUM_REQ-1:0]             rspValid,
  output logic                           rspOk,
  output logic                           rspErr,
  output logic [LINE_W-1:0]              rspData,
  output logic                           lockActive,
  output logic [IDX_W-1:0]               lockLine
);

  casStrobe_t        strobe;
  logic              idle, respond, misaligned, okR, errR;
  logic [ID_W-1:0]   winId, owner;
  logic [LINE_W-1:0] dataR;

  cas_arb #(.NUM_REQ(NUM_REQ)) u_arb (
    .clk(clk), .rstN(rstN), .enable(idle), .reqValid(reqValid),
    .grant(reqGrant), .winId(winId)
  );

  cas_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .anyGrant(|reqGrant), .misaligned(misaligned),
    .strobe(strobe), .idle(idle), .respond(respond)
  );

  cas_dp #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .winId(winId),
    .reqWide(reqWide), .reqAddr(reqAddr), .reqExpect(reqExpect),
    .reqDesire(reqDesire), .misaligned(misaligned), .lockHeld(lockActive),
    .lockLine(lockLine), .owner(owner), .okR(okR), .errR(errR), .dataR(dataR)
  );

  assign rspValid = respond ? (NUM_REQ'(1) << owner) : '0;
  assign rspOk    = respond & okR;
  assign rspErr   = respond & errR;
  assign rspData  = respond ? dataR : '0;

endmodule

// File: rtl/cas_unit_chk.sv
module cas_unit_chk #(
  parameter int NUM_REQ = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] reqValid,
  input logic [NUM_REQ-1:0] reqGrant,
  input logic [NUM_REQ-1:0] rspValid,
  input logic               rspOk,
  input logic               rspErr,
  input logic               lockActive
);

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqGrant));

  // R8
  grant_asked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant & ~reqValid) == '0);

  // R9
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rspValid));

  // R9
  rsp_flags_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid == '0) |-> (!rspOk && !rspErr));

  // R10
  lock_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockActive |=> (!lockActive && rspValid != '0));

  // R10
  no_grant_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockActive |-> (reqGrant == '0));

  // R7
  err_no_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid != '0 && rspErr) |-> !$past(lockActive));

  // R4
  write_before_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid != '0 && !rspErr) |-> $past(lockActive));

endmodule

bind cas_unit cas_unit_chk #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqGrant(reqGrant),
  .rspValid(rspValid), .rspOk(rspOk), .rspErr(rspErr), .lockActive(lockActive)
);

// File: tb/cas_unit_tb.sv
`timescale 1ns/1ps
module cas_unit_tb;
  localparam int NR = 2;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [NR-1:0]         reqValid = '0, reqWide = '0;
  logic [NR-1:0][AW-1:0] reqAddr = '0;
  logic [NR-1:0][127:0]  reqExpect = '0, reqDesire = '0;
  logic [NR-1:0]         reqGrant, rspValid;
  logic                  rspOk, rspErr, lockActive;
  logic [127:0]          rspData;
  logic [3:0]            lockLine;

  cas_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWide(reqWide),
    .reqAddr(reqAddr), .reqExpect(reqExpect), .reqDesire(reqDesire),
    .reqGrant(reqGrant), .rspValid(rspValid), .rspOk(rspOk), .rspErr(rspErr),
    .rspData(rspData), .lockActive(lockActive), .lockLine(lockLine)
  );

  int checks = 0;
  int fails  = 0;
  int rrPtr  = 0;
  logic [127:0] bm [16];

  task automatic chk(bit c, string r, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // Reference behaviour from the requirements
  task automatic model(bit wide, logic [7:0] a, logic [127:0] e, logic [127:0] d,
                       output bit ok, output bit err, output logic [127:0] obs);
    logic [127:0] cur;
    logic [63:0]  h;
    int idx;
    idx = int'(a[7:4]);
    err = wide ? (a[3:0] != 0) : (a[2:0] != 0);
    ok = 1'b0;
    obs = '0;
    if (!err) begin
      cur = bm[idx];
      if (wide) begin
        obs = cur;
        ok  = (cur == e);
        if (ok) bm[idx] = d;
      end else begin
        h   = a[3] ? cur[127:64] : cur[63:0];
        obs = {64'h0, h};
        ok  = (h == e[63:0]);
        if (ok) begin
          if (a[3]) bm[idx][127:64] = d[63:0];
          else      bm[idx][63:0]   = d[63:0];
        end
      end
    end
  endtask

  task automatic doOp(int id, bit wide, logic [7:0] a, logic [127:0] e,
                      logic [127:0] d, string r, output bit gotOk);
    bit mOk, mErr;
    logic [127:0] mObs;
    int t, n, lockSeen, expWin;
    gotOk = 1'b0;
    @(negedge clk);
    reqWide[id] = wide; reqAddr[id] = a;
    reqExpect[id] = e; reqDesire[id] = d; reqValid[id] = 1'b1;
    #1;
    t = 0;
    while (!reqGrant[id] && t < 100) begin @(negedge clk); #1; t++; end
    if (!reqGrant[id]) begin
      chk(0, {"R8 grant timeout ", r}, 0, 1);
      reqValid[id] = 1'b0;
      return;
    end
    expWin = reqValid[rrPtr] ? rrPtr : (rrPtr + 1) % NR;
    chk(expWin == id, {"R8 arbitration ", r}, id, expWin);
    rrPtr = (id + 1) % NR;
    model(wide, a, e, d, mOk, mErr, mObs);
    n = 0; lockSeen = 0;
    while (!rspValid[id] && n < 10) begin
      @(negedge clk); #1; n++;
      if (n == 1) reqValid[id] = 1'b0;
      if (lockActive) lockSeen++;
    end
    chk(n == (mErr ? 2 : 3), {"R9 latency ", r}, n, mErr ? 2 : 3);
    chk(rspValid == NR'(1 << id), {"R9 response target ", r}, rspValid, 1 << id);
    chk(lockSeen == (mErr ? 0 : 1), {"R10 lock window ", r}, lockSeen, mErr ? 0 : 1);
    chk(rspErr == mErr, {"R7 error flag ", r}, rspErr, mErr);
    chk(rspOk == mOk, {"success ", r}, rspOk, mOk);
    chk(rspData == mObs, {"observed ", r}, rspData, mObs);
    gotOk = rspOk;
  endtask

  function automatic logic [63:0] loPat(int l);
    return 64'h0000_BEEF_0000_0001 + 64'(l) * 64'h0000_0000_0103_0007;
  endfunction
  function automatic logic [63:0] hiPat(int l);
    return 64'hC0DE_0000_7700_0000 + 64'(l) * 64'h0101_0000_0000_0011;
  endfunction

  initial begin
    int cyc;
    for (cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit okA, okB, dummy;
    for (int i = 0; i < 16; i++) bm[i] = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(reqGrant == '0, "R1 grant idle", reqGrant, 0);
    chk(rspValid == '0, "R1 response idle", rspValid, 0);
    chk(lockActive == 1'b0, "R1 lock idle", lockActive, 0);
    rstN = 1'b1;

    // R8 requester 0 first after reset; R6 wide swap then narrow compare fails
    fork
      doOp(0, 1'b1, 8'h00, '0, {hiPat(20), loPat(20)}, "R6 wide vs narrow", okA);
      doOp(1, 1'b0, 8'h00, '0, {64'h0, 64'h5555_0000_0000_5555}, "R6 narrow vs wide", okB);
    join
    chk(okA && !okB, "R6 wide first wins", {okA, okB}, 2'b10);

    // Near-exhaustive sweep over every line and both halves
    for (int l = 0; l < 16; l++) begin
      int id;
      id = l % 2;
      doOp(id, 1'b1, {4'(l), 4'h0}, ~bm[l], '0, "R1/R4 readback", dummy);
      doOp(id, 1'b1, {4'(l), 4'h0}, bm[l], {hiPat(l), loPat(l)}, "R2 wide swap", dummy);
      for (int h = 0; h < 2; h++) begin
        logic [63:0] cur;
        cur = h ? bm[l][127:64] : bm[l][63:0];
        doOp(1 - id, 1'b0, {4'(l), 1'(h), 3'h0}, {64'h0, cur ^ 64'h1},
             {64'h0, ~cur}, "R4/R5 narrow mismatch", dummy);
        doOp(id, 1'b0, {4'(l), 1'(h), 3'h0}, {64'hFFFF, cur},
             {64'hAAAA, cur ^ 64'hF0F0_0000_0000_0F0F}, "R3/R5 narrow swap", dummy);
        doOp(1 - id, 1'b1, {4'(l), 4'h0}, ~bm[l], '0, "R3 other half kept", dummy);
      end
    end

    // R7 misaligned requests of both widths
    doOp(0, 1'b1, 8'h28, '0, '1, "R7 wide at 8", dummy);
    doOp(1, 1'b0, 8'h24, '0, '1, "R7 narrow at 4", dummy);
    doOp(0, 1'b1, 8'h2C, '0, '1, "R7 wide at 12", dummy);
    doOp(1, 1'b0, 8'h21, '0, '1, "R7 narrow at 1", dummy);
    doOp(0, 1'b1, 8'h20, ~bm[2], '0, "R7 line untouched", dummy);

    // R6 with requester 1 taking the lock first: narrow high swap, then wide fails
    doOp(0, 1'b1, 8'h50, ~bm[5], '0, "R4 readback", dummy);
    fork
      doOp(0, 1'b1, 8'h50, bm[5], {hiPat(40), loPat(40)}, "R6 wide after narrow", okA);
      doOp(1, 1'b0, 8'h58, {64'h0, bm[5][127:64]}, {64'h0, 64'h1234_5678_9ABC_DEF0},
           "R6 narrow before wide", okB);
    join
    chk(!okA && okB, "R6 narrow first wins", {okA, okB}, 2'b01);
    doOp(1, 1'b1, 8'h50, ~bm[5], '0, "R6 final line", dummy);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule